// File: doc/BRIEF.md
# Page Protection Bit Controller

This block keeps one write-protect bit for every 32-byte page of a serial byte-addressed memory: 128 bits for a 4096-byte array. A bit at 1 leaves its page open to normal writes. A bit at 0 locks the page. A bus front end delivers byte-level events: start, stop, received byte and master acknowledge. The block answers every received byte with a one-cycle acknowledge decision. It reads the data memory through a one-cycle-latency read port and exposes the whole protection vector so that the write path can gate programming.

A protection operation opens with a write-command byte and a two-byte address naming the page. A repeated start, a second write-command byte and a control byte follow. The control byte selects the operation. A read returns the page's bit in the top position of each byte and moves to the next page on every master acknowledge. A protect or unprotect requires the master to replay all 32 bytes of the page. The bit changes only if every byte matched and a stop follows the last byte. A timed programming interval then runs, during which the block ignores the bus.

Top module: `page_guard`

## Requirements
- R1: After reset every protection bit is 1, `busy` is 0, `cur_addr` is 0 and no acknowledge is pending.
- R2: A command byte is acknowledged only when its bit 0 is 0 (write). A command byte with bit 0 set is not acknowledged. In a correct sequence the first command, both address bytes, the second command after a repeated start, and a valid control byte are each acknowledged one cycle after the byte event.
- R3: The page number is taken from address bits 11..5, where the first address byte supplies bits 11..8 in its low nibble and the second supplies bits 7..0. If bits 4..0 are not all zero, the second address byte is not acknowledged and the sequence is dropped.
- R4: Only the two low bits of the control byte count: 00 reads, 01 protects (bit becomes 0), 11 unprotects (bit becomes 1), and 10 is not acknowledged. Bits 7..2 are ignored.
- R5: After a protect or unprotect control byte, the k-th following byte (k = 0..31) is compared with the stored byte at page base + k. It is acknowledged when equal.
- R6: From the first mismatching byte on, every byte of the operation goes unacknowledged. The closing stop then leaves the bit unchanged, and `busy` stays 0.
- R7: Programming starts only on a stop that follows exactly 32 matching bytes. `busy` is then high for PROG_CYC cycles, and the bit takes its new value as `busy` falls. A 33rd byte is not acknowledged and cancels the operation. A stop or a start before the 32nd byte also cancels it.
- R8: While `busy` is high, every received byte is not acknowledged and start/stop events are ignored. After `busy` falls, a write-command byte is acknowledged again.
- R9: After a successful programming, `cur_addr` holds the page base with bits 4..0 all ones.
- R10: During a read, `rd_byte` bit 7 is the protection bit of the current page and bits 6..0 are 0. A master acknowledge moves to the next page, with page 127 followed by page 0. A master non-acknowledge ends the read.
- R11: `prot_bits[p]` is the bit of page p. A programming changes only the addressed page's bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen on the bus (pulse) |
| ev_stop | input | 1 | Stop seen on the bus (pulse) |
| rx_vld | input | 1 | A byte from the master is complete (pulse) |
| rx_byte | input | 8 | Received byte, valid with rx_vld |
| mack_vld | input | 1 | Master acknowledge slot after a read byte (pulse) |
| mack_ok | input | 1 | 1 = master acknowledged, 0 = master released the line |
| mem_addr | output | 12 | Data memory read address |
| mem_rdata | input | 8 | Data memory read data, one cycle after mem_addr |
| ack_vld | output | 1 | Acknowledge decision valid (one cycle after rx_vld) |
| ack_ok | output | 1 | 1 = acknowledge the byte, 0 = leave line released |
| rd_byte | output | 8 | Byte to shift out during a protection read |
| busy | output | 1 | Protection bit programming in progress |
| cur_addr | output | 12 | Internal address counter |
| prot_bits | output | 128 | Protection bit of each page (1 = writable) |

## Verification
The assertions take for granted that the front end presents at most one of start, stop, received byte and master acknowledge in any cycle. They also take for granted that a chip-select mismatch never reaches this block, and that consecutive byte events are at least three cycles apart, so the prefetched memory byte has settled before it is compared. The stimulus applies each event as a single-cycle pulse and waits five cycles after every byte. Its memory model returns a computed byte one cycle after each address, which keeps every comparison inside that timing. Programming runs with a short interval so that many pages, every mismatch position class and both read wrap paths fit in one run.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_AHI, ST_ALO, ST_WAIT2, ST_CMD2,
    ST_CTL, ST_VER, ST_FULL, ST_RD, ST_PROG
  } pg_state_e;

  localparam logic [1:0] OP_READ    = 2'b00;
  localparam logic [1:0] OP_BAD     = 2'b10;
endpackage

// File: rtl/pg_timer.sv
module pg_timer #(
  parameter int PROG_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(PROG_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign done = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= CW'(PROG_CYC - 1);
      run_q <= 1'b1;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  tmr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);
endmodule

// File: rtl/pg_bitstore.sv
module pg_bitstore #(
  parameter int   PAGE_W = 7,
  parameter logic INIT   = 1'b1,
  localparam int  PAGES  = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_val,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [PAGES-1:0]  prot_q,
  output logic [7:0]        rd_byte
);
  for (genvar g = 0; g < PAGES; g++) begin : g_pg
    always_ff @(posedge clk) begin
      if (rst)
        prot_q[g] <= INIT;
      else if (wr_en && (wr_page == PAGE_W'(g)))
        prot_q[g] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_byte <= '0;
    else     rd_byte <= {prot_q[rd_page], 7'b0};
  end
endmodule

// File: rtl/pg_seq.sv
module pg_seq
  import pg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5,
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic              mack_vld,
  input  logic              mack_ok,
  input  logic [7:0]        mem_rdata,
  input  logic              tmr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic              tmr_start,
  output logic              bit_we,
  output logic              bit_val,
  output logic [PAGE_W-1:0] bit_page,
  output logic [PAGE_W-1:0] rd_page,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              busy
);
  pg_state_e         st_q, nxt;
  logic [ADDR_W-9:0] ahi_q;
  logic [ADDR_W-1:0] a_full;
  logic [PAGE_W-1:0] page_q, rd_page_q;
  logic [OFS_W-1:0]  idx_q;
  logic              fail_q, erase_q, acc, byte_ok;

  assign a_full  = {ahi_q, rx_byte};
  assign byte_ok = rx_vld && !ev_start && !ev_stop && (st_q != ST_PROG);

  always_comb begin
    nxt = st_q;
    acc = 1'b0;
    if (st_q == ST_PROG) begin
      if (tmr_done) nxt = ST_IDLE;
    end else if (ev_stop) begin
      nxt = (st_q == ST_FULL && !fail_q) ? ST_PROG : ST_IDLE;
    end else if (ev_start) begin
      nxt = (st_q == ST_WAIT2) ? ST_CMD2 : ST_CMD1;
    end else if (rx_vld) begin
      case (st_q)
        ST_CMD1, ST_CMD2: begin
          acc = !rx_byte[0];
          if (rx_byte[0])            nxt = ST_IDLE;
          else if (st_q == ST_CMD1)  nxt = ST_AHI;
          else                       nxt = ST_CTL;
        end
        ST_AHI: begin
          acc = 1'b1;
          nxt = ST_ALO;
        end
        ST_ALO: begin
          acc = (a_full[OFS_W-1:0] == '0);
          nxt = acc ? ST_WAIT2 : ST_IDLE;
        end
        ST_WAIT2: nxt = ST_IDLE;
        ST_CTL: begin
          acc = (rx_byte[1:0] != OP_BAD);
          if (rx_byte[1:0] == OP_READ) nxt = ST_RD;
          else if (rx_byte[0])         nxt = ST_VER;
          else                         nxt = ST_IDLE;
        end
        ST_VER: begin
          acc = !fail_q && (rx_byte == mem_rdata);
          if (idx_q == '1) nxt = ST_FULL;
        end
        default: nxt = st_q;
      endcase
    end else if (mack_vld && st_q == ST_RD && !mack_ok) begin
      nxt = ST_IDLE;
    end
  end

  assign tmr_start = (nxt == ST_PROG) && (st_q != ST_PROG);
  assign bit_we    = (st_q == ST_PROG) && tmr_done;
  assign bit_val   = erase_q;
  assign bit_page  = page_q;
  assign rd_page   = rd_page_q;
  assign busy      = (st_q == ST_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ahi_q     <= '0;
      page_q    <= '0;
      rd_page_q <= '0;
      idx_q     <= '0;
      fail_q    <= 1'b0;
      erase_q   <= 1'b0;
      ack_vld   <= 1'b0;
      ack_ok    <= 1'b0;
      mem_addr  <= '0;
      cur_addr  <= '0;
    end else begin
      st_q     <= nxt;
      ack_vld  <= rx_vld;
      ack_ok   <= acc;
      mem_addr <= {page_q, idx_q};
      if (st_q == ST_AHI && nxt == ST_ALO) ahi_q <= rx_byte[ADDR_W-9:0];
      if (st_q == ST_ALO && nxt == ST_WAIT2) begin
        page_q   <= a_full[ADDR_W-1:OFS_W];
        cur_addr <= {a_full[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      end
      if (st_q == ST_CTL && nxt == ST_VER) begin
        erase_q <= rx_byte[1];
        idx_q   <= '0;
        fail_q  <= 1'b0;
      end
      if (st_q == ST_CTL && nxt == ST_RD) rd_page_q <= page_q;
      if (st_q == ST_VER && byte_ok) begin
        idx_q <= idx_q + 1'b1;
        if (!acc) fail_q <= 1'b1;
      end
      if (st_q == ST_FULL && byte_ok) fail_q <= 1'b1;
      if (st_q == ST_RD && mack_vld && mack_ok && nxt == ST_RD)
        rd_page_q <= rd_page_q + 1'b1;
      if (bit_we) cur_addr <= {page_q, {OFS_W{1'b1}}};
    end
  end

  // R6
  fail_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_VER && fail_q && byte_ok) |=> (ack_vld && !ack_ok));
  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_vld) |=> (ack_vld && !ack_ok));
  // R2
  ack_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(rx_vld));
endmodule

// File: rtl/page_guard.sv
module page_guard #(
  parameter int   ADDR_W     = 12,
  parameter int   PAGE_BYTES = 32,
  parameter int   PROG_CYC   = 1000,
  parameter logic PROT_INIT  = 1'b1,
  localparam int  OFS_W      = $clog2(PAGE_BYTES),
  localparam int  PAGE_W     = ADDR_W - OFS_W,
  localparam int  PAGES      = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic              mack_vld,
  input  logic              mack_ok,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic [7:0]        rd_byte,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [PAGES-1:0]  prot_bits
);
  logic              tmr_start, tmr_done, bit_we, bit_val;
  logic [PAGE_W-1:0] bit_page, rd_page;

  pg_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .mack_vld(mack_vld),
    .mack_ok(mack_ok), .mem_rdata(mem_rdata), .tmr_done(tmr_done),
    .mem_addr(mem_addr), .ack_vld(ack_vld), .ack_ok(ack_ok),
    .tmr_start(tmr_start), .bit_we(bit_we), .bit_val(bit_val),
    .bit_page(bit_page), .rd_page(rd_page), .cur_addr(cur_addr),
    .busy(busy)
  );

  pg_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .done(tmr_done)
  );

  pg_bitstore #(.PAGE_W(PAGE_W), .INIT(PROT_INIT)) u_bits (
    .clk(clk), .rst(rst), .wr_en(bit_we), .wr_page(bit_page),
    .wr_val(bit_val), .rd_page(rd_page), .prot_q(prot_bits),
    .rd_byte(rd_byte)
  );

  // R11
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(prot_bits ^ $past(prot_bits)) <= 1);
  // R7
  prot_change_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_bits != $past(prot_bits)) |-> $fell(busy));
  // R9
  top_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (&cur_addr[OFS_W-1:0]));
endmodule

// File: tb/page_guard_bench.sv
`timescale 1ns/1ps
module page_guard_bench;
  localparam int PCYC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start = 0, ev_stop = 0, rx_vld = 0, mack_vld = 0, mack_ok = 0;
  logic [7:0]  rx_byte = '0;
  logic [11:0] mem_addr, cur_addr;
  logic [7:0]  mem_rdata, rd_byte;
  logic        ack_vld, ack_ok, busy;
  logic [127:0] prot_bits;
  logic [127:0] exp_prot = '1;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  page_guard #(.PROG_CYC(PCYC)) u_page_guard (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .mack_vld(mack_vld),
    .mack_ok(mack_ok), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .rd_byte(rd_byte), .busy(busy),
    .cur_addr(cur_addr), .prot_bits(prot_bits)
  );

  function automatic logic [7:0] fdat(input logic [11:0] a);
    return (a[7:0] * 8'd3) ^ {1'b0, a[11:5]};
  endfunction

  always_ff @(posedge clk) mem_rdata <= fdat(mem_addr);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    ev_start = 1; tick(1); ev_start = 0; tick(2);
  endtask

  task automatic do_stop();
    ev_stop = 1; tick(1); ev_stop = 0;
  endtask

  task automatic put(input logic [7:0] b, input logic exp, input string tag);
    rx_byte = b; rx_vld = 1; tick(1); rx_vld = 0;
    chk(ack_vld === 1'b1 && ack_ok === exp, tag, {ack_vld, ack_ok}, {1'b1, exp});
    tick(4);
  endtask

  task automatic head(input int page, input logic [7:0] ctl, input logic exp_ctl);
    logic [6:0] p = 7'(page);
    do_start();
    put(8'hA0, 1, "R2 first command");
    put({4'h0, p[6:3]}, 1, "R2 high address");
    put({p[2:0], 5'b0}, 1, "R3 low address");
    do_start();
    put(8'hA0, 1, "R2 second command");
    put(ctl, exp_ctl, "R4 control byte");
  endtask

  task automatic prog(input int page, input bit erase, input int bad, input int nbytes, input bit poll);
    logic [6:0] p = 7'(page);
    logic [7:0] ctl = erase ? 8'hC3 : 8'h5D;
    bit good = (nbytes == 32) && (bad < 0);
    int n;
    head(page, ctl, 1);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] d = fdat({p, 5'(k)});
      bit ex = (k < 32) && (bad < 0 || k < bad);
      if (k == bad) d = d ^ 8'h10;
      put(d, ex, k >= 32 ? "R7 extra byte" : (bad >= 0 && k >= bad) ? "R6 after mismatch" : "R5 verify byte");
    end
    do_stop();
    if (good) begin
      if (poll) begin
        tick(2);
        do_start();
        put(8'hA0, 0, "R8 poll while busy");
        chk(busy === 1'b1, "R8 still busy", busy, 1);
        while (busy) tick(1);
        do_start();
        put(8'hA0, 1, "R8 poll after busy");
        do_stop();
      end else begin
        n = 0;
        while (busy === 1'b1 && n < 100000) begin n++; tick(1); end
        chk(n == PCYC, "R7 busy length", n, PCYC);
      end
      exp_prot[p] = erase;
      chk(cur_addr == {p, 5'h1f}, "R9 address after program", cur_addr, {p, 5'h1f});
    end else begin
      tick(2);
      chk(busy === 1'b0, "R6 no programming", busy, 0);
    end
    tick(2);
    chk(prot_bits == exp_prot, "R11 protection vector", prot_bits, exp_prot);
  endtask

  task automatic rd_sweep(input int first, input int count);
    head(first, 8'h7C, 1);
    for (int i = 0; i < count; i++) begin
      int pg = (first + i) % 128;
      chk(rd_byte == {exp_prot[pg], 7'b0}, "R10 read byte", rd_byte, {exp_prot[pg], 7'b0});
      mack_ok = (i < count - 1); mack_vld = 1; tick(1); mack_vld = 0; tick(3);
    end
    do_stop();
    tick(2);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk(prot_bits == '1, "R1 bits after reset", prot_bits, '1);
    chk(busy === 1'b0 && ack_vld === 1'b0, "R1 idle after reset", {busy, ack_vld}, 0);
    chk(cur_addr == '0, "R1 address after reset", cur_addr, 0);

    do_start(); put(8'hA1, 0, "R2 read command refused"); do_stop(); tick(2);

    do_start(); put(8'hA0, 1, "R2 command"); put(8'h00, 1, "R2 high address");
    put(8'h23, 0, "R3 unaligned low address"); do_stop(); tick(2);
    chk(prot_bits == exp_prot, "R3 no change", prot_bits, exp_prot);

    head(3, 8'hF2, 0); do_stop(); tick(2);
    chk(busy === 1'b0, "R4 reserved code", busy, 0);

    prog(0, 0, -1, 32, 0);
    prog(127, 0, -1, 32, 0);
    prog(64, 0, -1, 32, 0);
    prog(5, 0, -1, 32, 0);
    prog(9, 0, 0, 32, 0);
    prog(9, 0, 17, 32, 0);
    prog(9, 0, 31, 32, 0);
    prog(10, 0, -1, 31, 0);
    prog(11, 0, -1, 33, 0);
    prog(64, 1, -1, 32, 0);
    prog(77, 0, -1, 32, 1);
    prog(0, 1, 3, 32, 0);

    rd_sweep(120, 12);
    rd_sweep(0, 130);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule